// File: doc/BRIEF.md
# Three-Digit Sequential Code Lock

This block is a clocked door lock that takes a combination as a series of small code values typed one after another. Each value arrives on a 4-bit bus together with a one-cycle strobe. The lock walks through one waiting step per digit. At each step the strobed value is compared with the stored digit for that step. A match moves the lock to the next step. A mismatch drops the lock into a dead error state. After the last digit matches, the lock raises its open output.

The open state and the error state are both final. Only the synchronous reset leaves them, and it always returns the lock to the first step with the door closed. The stored combination lives in three code registers. Each register is written from the same value bus through its own load strobe.

The controller state is one-hot. The all-zero code is the error state. The low state bits select the stored digit directly, and the top bit is the door output.

Top module: `lock_combo`

## Requirements
- R1: One cycle after `rst` is high, `open_o` is 0 and the lock waits at step one: strobed values then match against stored digit 1 first.
- R2: When the three strobed values equal stored digits 1, 2 and 3 in that order, `open_o` becomes 1 on the clock edge that takes the third value. It is 0 after only the first or the first two values.
- R3: A cycle with `strobe_i` low leaves the lock state unchanged whatever `value_i` carries.
- R4: A strobed value that differs from the digit of the current step sends the lock to the error state. Further values, including the correct ones, then never open it.
- R5: Once open, `open_o` stays 1 under any further strobes or values until `rst` is high.
- R6: The error state is held until reset, with `open_o` at 0.
- R7: `rst` wins over every other input. A strobe presented in the reset cycle is not evaluated, and the lock still waits at step one afterwards.
- R8: Code register k (k = 0, 1, 2 for digits 1, 2, 3) loads `value_i` at the clock edge where `load_i[k]` is 1. The other two registers keep their contents.
- R9: Reset does not clear the code registers.
- R10: When a strobe and a load of the current step's register fall in the same cycle, the comparison uses the digit stored before that edge. The new digit applies from the next cycle.
- R11: The controller state is always one-hot or all-zero (error). Any other code is recovered to error, so the lock never opens from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to step one, active high |
| value_i | input | 4 | Code value being entered or loaded |
| strobe_i | input | 1 | One-cycle pulse marking a value for comparison |
| load_i | input | 3 | Per-register load strobes; bit k writes digit k+1 |
| open_o | output | 1 | 1 when the door is open |

## Verification
The entry path is driven with the exact combination, with a wrong digit at each of the three steps, and with a wrong value presented without a strobe. These cases separate real advancement from reacting to the bus alone, and show that an error at any step is terminal. Strobes after opening and after an error show that both end states hold. A strobe given together with reset shows that reset takes priority. Register loads are applied to one digit at a time, across a reset, and in the same cycle as a strobe. These cases show that only the selected register changes, that its contents survive reset, and that a comparison in that cycle uses the old digit.

// File: rtl/lock_pkg.sv
package lock_pkg;
    localparam int LK_STEPS   = 3;
    localparam int LK_DIGIT_W = 4;

    // True when the vector has at most one bit set
    function automatic logic at_most_one(input logic [LK_STEPS:0] v);
        return (v & (v - 1'b1)) == '0;
    endfunction
endpackage

// File: rtl/lock_code_bank.sv
module lock_code_bank #(
    parameter int STEPS   = 3,
    parameter int DIGIT_W = 4
) (
    input  logic                       clk,
    input  logic [STEPS-1:0]           load_i,
    input  logic [DIGIT_W-1:0]         value_i,
    output logic [STEPS*DIGIT_W-1:0]   codes_o
);
    genvar k;
    generate
        for (k = 0; k < STEPS; k++) begin : g_digit
            logic [DIGIT_W-1:0] digit_d;
            logic [DIGIT_W-1:0] digit_q;

            always_comb begin
                digit_d = digit_q;
                if (load_i[k]) begin
                    digit_d = value_i;
                end
            end

            always_ff @(posedge clk) begin
                digit_q <= digit_d;
            end

            assign codes_o[k*DIGIT_W +: DIGIT_W] = digit_q;
        end
    endgenerate
endmodule

// File: rtl/lock_digit_match.sv
module lock_digit_match #(
    parameter int STEPS   = 3,
    parameter int DIGIT_W = 4
) (
    input  logic [STEPS-1:0]           sel_i,
    input  logic [STEPS*DIGIT_W-1:0]   codes_i,
    input  logic [DIGIT_W-1:0]         value_i,
    output logic                       match_o
);
    logic [STEPS*DIGIT_W-1:0] gated;
    logic [DIGIT_W-1:0]       picked;

    genvar k;
    generate
        for (k = 0; k < STEPS; k++) begin : g_gate
            assign gated[k*DIGIT_W +: DIGIT_W] =
                codes_i[k*DIGIT_W +: DIGIT_W] & {DIGIT_W{sel_i[k]}};
        end
    endgenerate

    // AND-OR select of the one-hot chosen digit
    always_comb begin
        picked = '0;
        for (int i = 0; i < STEPS; i++) begin
            picked = picked | gated[i*DIGIT_W +: DIGIT_W];
        end
    end

    assign match_o = (|sel_i) && (picked == value_i);
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl #(
    parameter int STEPS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_i,
    input  logic             match_i,
    output logic [STEPS-1:0] sel_o,
    output logic             open_o,
    output logic [STEPS:0]   state_o
);
    localparam int SW = STEPS + 1;
    localparam logic [SW-1:0] ST_FIRST = SW'(1);
    localparam logic [SW-1:0] ST_ERR   = '0;

    typedef struct packed {
        logic [SW-1:0] state;
    } ctrl_t;

    ctrl_t cur_q;
    ctrl_t nxt_d;
    logic  legal;
    logic  waiting;

    assign legal   = (cur_q.state & (cur_q.state - 1'b1)) == '0;
    assign waiting = |cur_q.state[STEPS-1:0];

    always_comb begin
        nxt_d = cur_q;
        if (rst) begin
            nxt_d.state = ST_FIRST;
        end else if (!legal) begin
            nxt_d.state = ST_ERR;
        end else if (strobe_i && waiting) begin
            if (match_i) begin
                nxt_d.state = cur_q.state << 1;
            end else begin
                nxt_d.state = ST_ERR;
            end
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign sel_o   = cur_q.state[STEPS-1:0];
    assign open_o  = cur_q.state[STEPS];
    assign state_o = cur_q.state;
endmodule

// File: rtl/lock_combo.sv
module lock_combo #(
    parameter int STEPS   = lock_pkg::LK_STEPS,
    parameter int DIGIT_W = lock_pkg::LK_DIGIT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIGIT_W-1:0] value_i,
    input  logic               strobe_i,
    input  logic [STEPS-1:0]   load_i,
    output logic               open_o
);
    logic [STEPS*DIGIT_W-1:0] codes;
    logic [STEPS-1:0]         sel;
    logic                     match;
    logic [STEPS:0]           state;

    lock_code_bank #(.STEPS(STEPS), .DIGIT_W(DIGIT_W)) u_bank (
        .clk     (clk),
        .load_i  (load_i),
        .value_i (value_i),
        .codes_o (codes)
    );

    lock_digit_match #(.STEPS(STEPS), .DIGIT_W(DIGIT_W)) u_match (
        .sel_i   (sel),
        .codes_i (codes),
        .value_i (value_i),
        .match_o (match)
    );

    lock_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe_i),
        .match_i  (match),
        .sel_o    (sel),
        .open_o   (open_o),
        .state_o  (state)
    );
endmodule

// File: rtl/lock_combo_chk.sv
module lock_combo_chk #(
    parameter int STEPS = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           strobe_i,
    input logic           match,
    input logic           open_o,
    input logic [STEPS:0] state
);
    p_reset_first_r1: assert property (@(posedge clk)
        rst |=> (state == (STEPS+1)'(1)) && !open_o);

    p_open_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> $past(strobe_i) && $past(state[STEPS-1]) && $past(match));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !strobe_i && $onehot0(state) |=> $stable(state));

    p_mismatch_err_r4: assert property (@(posedge clk) disable iff (rst)
        strobe_i && (|state[STEPS-1:0]) && !match |=> state == '0);

    p_open_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        open_o |=> open_o);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        state == '0 |=> state == '0);

    p_legal_code_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(state));
endmodule

bind lock_combo lock_combo_chk #(.STEPS(STEPS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe_i),
    .match    (match),
    .open_o   (open_o),
    .state    (state)
);

// File: tb/lock_combo_tb.sv
module lock_combo_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic [3:0] value_i = '0;
    logic       strobe_i = 1'b0;
    logic [2:0] load_i = '0;
    logic       open_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lock_combo u_dut (
        .clk      (clk),
        .rst      (rst),
        .value_i  (value_i),
        .strobe_i (strobe_i),
        .load_i   (load_i),
        .open_o   (open_o)
    );

    task automatic check_open(input logic exp, input string tag);
        checks++;
        if (open_o !== exp) begin
            failures++;
            $display("FAIL %s: open_o actual=%b expected=%b", tag, open_o, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic enter(input logic [3:0] v);
        @(negedge clk); value_i = v; strobe_i = 1'b1;
        @(negedge clk); strobe_i = 1'b0; value_i = 4'hF;
    endtask

    task automatic load_one(input int k, input logic [3:0] v);
        @(negedge clk); value_i = v; load_i = 3'b001 << k;
        @(negedge clk); load_i = '0;
    endtask

    task automatic enter_code(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
        enter(a); enter(b); enter(c);
    endtask

    task automatic t_reset_state();
        do_reset();
        check_open(1'b0, "R1 closed after reset");
        enter_code(4'h3, 4'h4, 4'h2);
        check_open(1'b1, "R1 waits at step one");
    endtask

    task automatic t_open_sequence();
        do_reset();
        enter(4'h3); check_open(1'b0, "R2 one digit");
        enter(4'h4); check_open(1'b0, "R2 two digits");
        enter(4'h2); check_open(1'b1, "R2 three digits");
    endtask

    task automatic t_no_strobe();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); value_i = 4'(i + 8);
        end
        check_open(1'b0, "R3 idle values");
        enter_code(4'h3, 4'h4, 4'h2);
        check_open(1'b1, "R3 no advance or error without strobe");
    endtask

    task automatic t_wrong_each_step();
        logic [3:0] good [3];
        good[0] = 4'h3; good[1] = 4'h4; good[2] = 4'h2;
        for (int k = 0; k < 3; k++) begin
            do_reset();
            for (int j = 0; j < k; j++) enter(good[j]);
            enter(good[k] ^ 4'h8);
            for (int j = k; j < 3; j++) enter(good[j]);
            check_open(1'b0, "R4 wrong digit is terminal");
        end
        enter_code(4'h3, 4'h4, 4'h2);
        check_open(1'b0, "R6 error held under correct code");
    endtask

    task automatic t_open_hold();
        do_reset();
        enter_code(4'h3, 4'h4, 4'h2);
        enter(4'h0); enter(4'h3);
        repeat (3) @(negedge clk);
        check_open(1'b1, "R5 open held");
        do_reset();
        check_open(1'b0, "R5 reset closes");
    endtask

    task automatic t_reset_override();
        do_reset();
        enter_code(4'h3, 4'h4, 4'h2);
        @(negedge clk); rst = 1'b1; strobe_i = 1'b1; value_i = 4'h3;
        @(negedge clk); rst = 1'b0; strobe_i = 1'b0;
        check_open(1'b0, "R7 reset beats strobe");
        enter_code(4'h3, 4'h4, 4'h2);
        check_open(1'b1, "R7 strobe in reset cycle not taken");
    endtask

    task automatic t_load();
        load_one(1, 4'h7);
        do_reset();
        enter_code(4'h3, 4'h4, 4'h2);
        check_open(1'b0, "R8 old digit 2 rejected");
        do_reset();
        enter_code(4'h3, 4'h7, 4'h2);
        check_open(1'b1, "R8 only digit 2 changed");
        do_reset(); do_reset();
        enter_code(4'h3, 4'h7, 4'h2);
        check_open(1'b1, "R9 code kept over reset");
    endtask

    task automatic t_load_with_strobe();
        do_reset();
        @(negedge clk); value_i = 4'h6; strobe_i = 1'b1; load_i = 3'b001;
        @(negedge clk); strobe_i = 1'b0; load_i = '0;
        enter(4'h7); enter(4'h2);
        check_open(1'b0, "R10 compare used old digit");
        do_reset();
        enter_code(4'h6, 4'h7, 4'h2);
        check_open(1'b1, "R10 new digit applies next");
    endtask

    initial begin
        load_one(0, 4'h3);
        load_one(1, 4'h4);
        load_one(2, 4'h2);
        t_reset_state();
        t_open_sequence();
        t_no_strobe();
        t_wrong_each_step();
        t_open_hold();
        t_reset_override();
        t_load();
        t_load_with_strobe();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule